// File: doc/BRIEF.md
# Auto-Increment Register Bank Controller

This block is the register side of a two-wire serial target. A byte-level front end, which is not part of this block, handles the wire protocol. It passes in START and STOP events, a strobe for each byte that is moved, the byte value, and the read/write bit it captured in the address phase. In the write direction, the first byte after a START is a pointer. After that, data arrives as pairs: high byte first, then low byte. Each completed pair is committed to the register the pointer names. A burst then moves to the next address on its own, until a START or STOP ends it.

The bank holds three kinds of storage. Sixteen 10-bit channel registers sit at addresses 0–15. Two 10-bit common-level registers sit at addresses 18 and 19. Four full 16-bit auxiliary registers sit at addresses 60–63. Bit 15 of address 60 is a write-protect flag, and a burst may not change it. Any other address has no storage. It reads as zero and ignores writes. A burst that starts in the channel range therefore steps through the two empty slots, 16 and 17, before it reaches the common-level pair.

In the read direction, the block presents the register named by the last pointer byte, high byte first. It produces an acknowledge pulse for every byte received in the write direction.

Top module: `regbank_seq`

## Requirements
- R1: After reset every register holds zero, so any read returns 0x0000, and `ack_out` is low.
- R2: The first write-direction byte after a START is the pointer. Its bits 5:0 give the address and its bits 7:6 must be 00. If bits 7:6 are not 00, all data bytes up to the next START or STOP are ignored.
- R3: A register is written only when the low byte of its pair arrives. A START or STOP that comes after the high byte and before the low byte leaves the register unchanged.
- R4: Each completed pair advances the write address by one. A burst that begins at address 14 writes 14 and 15, skips 16 and 17 with no effect, then writes 18 and 19.
- R5: Channel and common-level registers keep bits 9:0, taken from high-byte bits 1:0 and the low byte. On read, bits 15:10 are zero.
- R6: Addresses 16, 17, 20–23 and 24–59 read as 0x0000, and writes to them have no effect.
- R7: A pair whose high byte has bits 7:6 equal to 01 is discarded. It still uses up one step of the burst.
- R8: Addresses 60–63 store all 16 bits. Bit 15 of address 60 is written only by the first pair after a pointer byte. Later pairs of a burst keep its old value and write the other bits.
- R9: `ack_out` is high in the cycle after each byte accepted in the write direction, and low after bytes in the read direction.
- R10: In the read direction, `rd_byte` shows the high byte of the register named by the last pointer byte. It shows the low byte after one byte strobe and the high byte again after the next. A START or STOP returns it to the high byte. Burst advance does not move the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| byte_vld | input | 1 | One-cycle pulse: a byte was received (write) or sent (read) |
| byte_in | input | 8 | Received byte, valid with `byte_vld` |
| rw_bit | input | 1 | Direction from the address phase, 1 = read |
| rd_byte | output | 8 | Byte to transmit in the read direction |
| ack_out | output | 1 | Acknowledge decision for the last received byte |

## Verification
The hardest situations to reach are a burst whose last pair is cut off by a repeated START, and a burst that crosses the write-protect register. Both need exact multi-byte sequences with the terminating event in one particular byte slot. The bench builds these with byte-level tasks. One burst lands its second pair on address 60, so the protect bit must survive while the other bits change. Another burst sends a lone high byte and then a START, and the reads that follow show which registers changed.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic [1:0] {S_PTR, S_HI, S_LO, S_SKIP} wseq_e;
endpackage

// File: rtl/regbank_wr_seq.sv
module regbank_wr_seq
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              byte_vld,
   input  logic              rw_bit,
   input  byte_t             byte_in,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_first,
   output word_t             wr_val,
   output logic [ADDR_W-1:0] base_addr
);
   wseq_e             st_q;
   logic [ADDR_W-1:0] off_q;
   byte_t             hi_q;
   logic              wr_byte;
   logic              ptr_ok;

   assign wr_byte = byte_vld && !rw_bit && !bus_start && !bus_stop;
   assign ptr_ok  = (byte_in[BYTE_W-1:ADDR_W] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_PTR;
         base_addr <= '0;
         off_q     <= '0;
         hi_q      <= '0;
      end else if (bus_start || bus_stop) begin
         st_q <= S_PTR;
      end else if (wr_byte) begin
         unique case (st_q)
            S_PTR: begin
               if (ptr_ok) begin
                  base_addr <= byte_in[ADDR_W-1:0];
                  off_q     <= '0;
                  st_q      <= S_HI;
               end else begin
                  st_q <= S_SKIP;
               end
            end
            S_HI: begin
               hi_q <= byte_in;
               st_q <= S_LO;
            end
            S_LO: begin
               off_q <= off_q + 1'b1;
               st_q  <= S_HI;
            end
            default: st_q <= S_SKIP;
         endcase
      end
   end

   assign wr_fire  = wr_byte && (st_q == S_LO) && (hi_q[7:6] != 2'b01);
   assign wr_addr  = base_addr + off_q;
   assign wr_first = (off_q == '0);
   assign wr_val   = {hi_q, byte_in};
endmodule

// File: rtl/regbank_store.sv
module regbank_store
   import regbank_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CH_N      = 16,
   parameter int VC_N      = 2,
   parameter int VC_BASE   = 18,
   parameter int MISC_N    = 4,
   parameter int MISC_BASE = 60,
   parameter int DATA_W    = 10,
   parameter int WP_REG    = 0,
   parameter int WP_BIT    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_first,
   input  word_t             wr_val,
   input  logic [ADDR_W-1:0] rd_addr,
   output word_t             rd_val
);
   localparam int NARROW_N = CH_N + VC_N;
   localparam int SLOT_N   = NARROW_N + MISC_N;

   logic [SLOT_N-1:0] hit;
   word_t             val [SLOT_N];

   for (genvar i = 0; i < NARROW_N; i++) begin : g_narrow
      localparam logic [ADDR_W-1:0] SLOT_A =
         (i < CH_N) ? ADDR_W'(i) : ADDR_W'(VC_BASE + i - CH_N);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                             q <= '0;
         else if (wr_fire && wr_addr == SLOT_A)  q <= wr_val[DATA_W-1:0];
      end
      assign hit[i] = (rd_addr == SLOT_A);
      assign val[i] = {{(WORD_W-DATA_W){1'b0}}, q};
   end

   for (genvar j = 0; j < MISC_N; j++) begin : g_misc
      localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(MISC_BASE + j);
      word_t q;
      if (j == WP_REG) begin : g_guard
         word_t nxt;
         always_comb begin
            nxt = wr_val;
            if (!wr_first) nxt[WP_BIT] = q[WP_BIT];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)                             q <= '0;
            else if (wr_fire && wr_addr == SLOT_A)  q <= nxt;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)                             q <= '0;
            else if (wr_fire && wr_addr == SLOT_A)  q <= wr_val;
         end
      end
      assign hit[NARROW_N+j] = (rd_addr == SLOT_A);
      assign val[NARROW_N+j] = q;
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < SLOT_N; k++) begin
         if (hit[k]) rd_val = val[k];
      end
   end
endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port
   import regbank_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bus_start,
   input  logic  bus_stop,
   input  logic  byte_vld,
   input  logic  rw_bit,
   input  word_t rd_val,
   output logic  rd_phase,
   output byte_t rd_byte
);
   always_ff @(posedge clk) begin
      if (!rst_n)                       rd_phase <= 1'b0;
      else if (bus_start || bus_stop)   rd_phase <= 1'b0;
      else if (byte_vld && rw_bit)      rd_phase <= !rd_phase;
   end

   assign rd_byte = rd_phase ? rd_val[BYTE_W-1:0] : rd_val[WORD_W-1:BYTE_W];
endmodule

// File: rtl/regbank_seq.sv
module regbank_seq
   import regbank_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CH_N      = 16,
   parameter int VC_N      = 2,
   parameter int VC_BASE   = 18,
   parameter int MISC_N    = 4,
   parameter int MISC_BASE = 60,
   parameter int DATA_W    = 10,
   parameter int WP_REG    = 0,
   parameter int WP_BIT    = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   input  logic       rw_bit,
   output logic [7:0] rd_byte,
   output logic       ack_out
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   initial begin
      if (ADDR_W < 1 || ADDR_W > BYTE_W - 1)
         $fatal(1, "ADDR_W must leave a zero field in the pointer byte");
      if (DATA_W < 1 || DATA_W > WORD_W)
         $fatal(1, "DATA_W out of range");
      if (VC_BASE < CH_N || VC_BASE + VC_N > MISC_BASE)
         $fatal(1, "register ranges overlap");
      if (MISC_BASE + MISC_N > ADDR_SPAN)
         $fatal(1, "aux range exceeds address space");
      if (WP_REG >= MISC_N || WP_BIT >= WORD_W)
         $fatal(1, "protect bit outside aux space");
   end

   logic              wr_fire;
   logic [ADDR_W-1:0] wr_addr;
   logic              wr_first;
   word_t             wr_val;
   logic [ADDR_W-1:0] rd_addr;
   word_t             rd_val;
   logic              rd_phase;

   regbank_wr_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_vld(byte_vld), .rw_bit(rw_bit), .byte_in(byte_in),
      .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_first(wr_first),
      .wr_val(wr_val), .base_addr(rd_addr)
   );

   regbank_store #(
      .ADDR_W(ADDR_W), .CH_N(CH_N), .VC_N(VC_N), .VC_BASE(VC_BASE),
      .MISC_N(MISC_N), .MISC_BASE(MISC_BASE), .DATA_W(DATA_W),
      .WP_REG(WP_REG), .WP_BIT(WP_BIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
      .wr_first(wr_first), .wr_val(wr_val), .rd_addr(rd_addr), .rd_val(rd_val)
   );

   regbank_rd_port u_rd (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_vld(byte_vld), .rw_bit(rw_bit), .rd_val(rd_val),
      .rd_phase(rd_phase), .rd_byte(rd_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ack_out <= 1'b0;
      else        ack_out <= byte_vld && !rw_bit;
   end
endmodule

// File: rtl/regbank_seq_chk.sv
module regbank_seq_chk #(
   parameter int ADDR_W  = 6,
   parameter int CH_N    = 16,
   parameter int VC_BASE = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_start,
   input logic              bus_stop,
   input logic              byte_vld,
   input logic              rw_bit,
   input logic              ack_out,
   input logic [7:0]        rd_byte,
   input logic              rd_phase,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              wr_fire
);
   // R3: a commit needs a data byte that no bus event cut short
   a_r3_commit_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> (byte_vld && !bus_start && !bus_stop));

   // R10: the read direction never writes the bank
   a_r10_no_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rw_bit |-> !wr_fire);

   // R9: acknowledge follows each write-direction byte
   a_r9_ack_write: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !rw_bit) |=> ack_out);

   // R9: no acknowledge from the target after read-direction bytes
   a_r9_no_ack_read: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && rw_bit) |=> !ack_out);

   // R5: upper six bits of a narrow register read back as zero
   a_r5_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_phase && (int'(rd_addr) < CH_N)) |-> (rd_byte[7:2] == 6'd0));

   // R6: empty slots between channel and common-level ranges read zero
   a_r6_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(rd_addr) >= CH_N) && (int'(rd_addr) < VC_BASE)) |-> (rd_byte == 8'd0));

   // R10: bus events return the read side to the high byte
   a_r10_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start || bus_stop) |=> !rd_phase);
endmodule

bind regbank_seq regbank_seq_chk #(
   .ADDR_W(ADDR_W), .CH_N(CH_N), .VC_BASE(VC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
   .byte_vld(byte_vld), .rw_bit(rw_bit), .ack_out(ack_out), .rd_byte(rd_byte),
   .rd_phase(rd_phase), .rd_addr(rd_addr), .wr_fire(wr_fire)
);

// File: tb/tb_regbank_seq.sv
module tb_regbank_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0;
   logic       bus_stop = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = 8'd0;
   logic       rw_bit = 1'b0;
   logic [7:0] rd_byte;
   logic       ack_out;

   always #5 clk = ~clk;

   regbank_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_vld(byte_vld), .byte_in(byte_in), .rw_bit(rw_bit),
      .rd_byte(rd_byte), .ack_out(ack_out)
   );

   int checks = 0;
   int errors = 0;

   // vector: pointer, high byte, low byte, expected readback
   localparam int NV = 9;
   localparam logic [39:0] VEC [NV] = '{
      {8'h00, 8'hFF, 8'hA5, 16'h03A5},   // R5 channel keeps 10 bits
      {8'h0F, 8'h02, 8'h11, 16'h0211},   // R5 last channel
      {8'h12, 8'h01, 8'h80, 16'h0180},   // R5 common-level at 18
      {8'h13, 8'h03, 8'hFF, 16'h03FF},   // R5 common-level at 19
      {8'h10, 8'h03, 8'h33, 16'h0000},   // R6 address 16 reads zero
      {8'h3D, 8'hBE, 8'hEF, 16'hBEEF},   // R8 aux register 61
      {8'h1E, 8'h12, 8'h34, 16'h0000},   // R6 undefined address 30
      {8'h05, 8'h41, 8'h00, 16'h0000},   // R7 high bits 01 discarded
      {8'h16, 8'h02, 8'h22, 16'h0000}    // R6 address 22 reads zero
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ev_start(input logic dir);
      @(negedge clk); bus_start = 1'b1; rw_bit = dir;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic ev_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); byte_vld = 1'b1; byte_in = b;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); byte_vld = 1'b1;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic read_reg(input logic [7:0] ptr, output logic [15:0] w);
      ev_start(1'b0);
      put(ptr);
      ev_start(1'b1);
      w[15:8] = rd_byte;
      strobe();
      w[7:0] = rd_byte;
      strobe();
      ev_stop();
   endtask

   task automatic write_reg(input logic [7:0] ptr, input logic [7:0] hi, input logic [7:0] lo);
      ev_start(1'b0);
      put(ptr);
      put(hi);
      put(lo);
      ev_stop();
   endtask

   initial begin : main
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ack low after reset", {15'd0, ack_out}, 16'd0);
      read_reg(8'h00, w);   chk("R1 ch0 reset", w, 16'h0000);
      read_reg(8'h3C, w);   chk("R1 aux60 reset", w, 16'h0000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         write_reg(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
         read_reg(VEC[i][39:32], w);
         chk($sformatf("R5/R6/R7/R8 vector %0d", i), w, VEC[i][15:0]);
      end

      // R9 acknowledge in both directions
      ev_start(1'b0);
      put(8'h00);
      chk("R9 ack after write byte", {15'd0, ack_out}, 16'd1);
      ev_start(1'b1);
      strobe();
      chk("R9 no ack after read byte", {15'd0, ack_out}, 16'd0);
      ev_stop();

      // R3 abort by STOP after high byte
      ev_start(1'b0); put(8'h00); put(8'h01); ev_stop();
      read_reg(8'h00, w);   chk("R3 stop after high byte", w, 16'h03A5);
      // R3 abort by START after high byte
      ev_start(1'b0); put(8'h00); put(8'h02); ev_start(1'b0); ev_stop();
      read_reg(8'h00, w);   chk("R3 start after high byte", w, 16'h03A5);

      // R4 burst across the empty slots
      ev_start(1'b0); put(8'h0E);
      put(8'h00); put(8'h0E);
      put(8'h00); put(8'h0F);
      put(8'h03); put(8'hAA);
      put(8'h03); put(8'hBB);
      put(8'h02); put(8'h22);
      put(8'h01); put(8'h11);
      ev_stop();
      read_reg(8'h0E, w);   chk("R4 burst slot 14", w, 16'h000E);
      read_reg(8'h0F, w);   chk("R4 burst slot 15", w, 16'h000F);
      read_reg(8'h10, w);   chk("R4 burst slot 16 empty", w, 16'h0000);
      read_reg(8'h11, w);   chk("R4 burst slot 17 empty", w, 16'h0000);
      read_reg(8'h12, w);   chk("R4 burst slot 18", w, 16'h0222);
      read_reg(8'h13, w);   chk("R4 burst slot 19", w, 16'h0111);

      // R3 burst cut by START mid-pair
      ev_start(1'b0); put(8'h00);
      put(8'h01); put(8'h01);
      put(8'h02); put(8'h02);
      put(8'h03);
      ev_start(1'b0); ev_stop();
      read_reg(8'h00, w);   chk("R4 partial burst ch0", w, 16'h0101);
      read_reg(8'h01, w);   chk("R4 partial burst ch1", w, 16'h0202);
      read_reg(8'h02, w);   chk("R3 partial burst ch2 kept", w, 16'h0000);

      // R7 discarded pair still advances the burst
      ev_start(1'b0); put(8'h06);
      put(8'h41); put(8'h55);
      put(8'h00); put(8'h77);
      ev_stop();
      read_reg(8'h06, w);   chk("R7 bad pair no write", w, 16'h0000);
      read_reg(8'h07, w);   chk("R7 next slot written", w, 16'h0077);

      // R10 repeated-start read after burst uses pointer byte address
      ev_start(1'b0); put(8'h08);
      put(8'h01); put(8'h23);
      put(8'h01); put(8'h45);
      ev_start(1'b1);
      w[15:8] = rd_byte;
      strobe();
      w[7:0] = rd_byte;
      chk("R10 repeated-start read", w, 16'h0123);
      strobe();
      chk("R10 wraps to high byte", {8'd0, rd_byte}, 16'h0001);
      ev_stop();
      read_reg(8'h09, w);   chk("R4 second burst slot", w, 16'h0145);

      // R8 protect bit
      write_reg(8'h3C, 8'h80, 8'h01);
      read_reg(8'h3C, w);   chk("R8 single write sets protect", w, 16'h8001);
      ev_start(1'b0); put(8'h3B);
      put(8'h00); put(8'h00);
      put(8'h00); put(8'h07);
      ev_stop();
      read_reg(8'h3C, w);   chk("R8 burst keeps protect bit", w, 16'h8007);
      write_reg(8'h3C, 8'h00, 8'h07);
      read_reg(8'h3C, w);   chk("R8 single write clears protect", w, 16'h0007);

      // R2 pointer with nonzero top bits
      ev_start(1'b0); put(8'h40);
      put(8'h03); put(8'h99);
      ev_stop();
      read_reg(8'h00, w);   chk("R2 bad pointer ignored", w, 16'h0101);

      // R1 reset clears everything again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      read_reg(8'h13, w);   chk("R1 reset clears common-level", w, 16'h0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule